// File: doc/BRIEF.md
# Multi-Channel Trapezoidal Pulse Shaper

This block shapes digitised detector pulses into trapezoids. Each lane takes one signed ADC sample per clock together with a valid flag. Each valid sample yields one shaped result, and the height of the flat top tracks the energy of the pulse. The impulse response is a fixed finite sequence. It undoes a step-like preamplifier pulse, which is a first difference, and then builds a trapezoid from it. The response is a run of `RISE` taps at `+GAIN`, then `FLAT` taps at zero, then `RISE` taps at `-GAIN`. A slow leading edge therefore does not lower the plateau.

There are no multipliers in the datapath. The delay line of each lane is read one bit plane at a time. Every plane addresses small constant tables, one per group of taps, and each table holds every possible sum of that group's coefficients. The per-plane sums are registered. A shift-and-add stage then combines them, and the sign plane carries negative weight. That result is rounded, scaled down by `2^SHIFT` and registered. All bit planes are unrolled, so every lane accepts a sample on every clock. The lanes are identical copies that run side by side.

Top module: `trapezoid_shaper`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line and the pipeline. While `rst` is held, and from then until the first new result, `out_valid` is 0 and `out_sample` is 0. Results after a reset treat all earlier history as zero samples.
- R2: Each lane computes y = Σ h[i]·x[i], where x[0] is the newest valid sample and x[i] is the i-th older one. Samples are `IN_W`-bit two's complement. The taps are h[i] = +GAIN for i < RISE, h[i] = 0 for RISE ≤ i < RISE+FLAT, and h[i] = −GAIN for the remaining RISE taps. The tap count is 2·RISE+FLAT, which is 16 by default.
- R3: The output is (y + 2^(SHIFT−1)) arithmetically shifted right by SHIFT. This is round-to-nearest with ties toward +∞. Only the low `OUT_W` bits are presented, in two's complement.
- R4: If a sample is captured at clock edge t, its result is on `out_valid`/`out_sample` right after edge t+2. The lane accepts a new sample on every edge.
- R5: A cycle with `in_valid` low leaves the delay line unchanged, produces no `out_valid`, and leaves `out_sample` holding its last value.
- R6: Consider a step of height H that climbs linearly over r samples, with r ≤ FLAT+1. It reaches a plateau of exactly GAIN·RISE·H/2^SHIFT (rounded per R3), whatever r is. With the defaults and H = 1000 this is 9000.
- R7: Full-scale inputs (+8191 and −8192 at the default width) never overflow. The output magnitude never exceeds the rounded value of 2·RISE·GAIN·2^(IN_W−1)/2^SHIFT, which is 147456 by default.
- R8: The `NCH` lanes run independently and at the same time. The sample and valid flag of one lane never affect another lane.
- R9: Setting RISE = 3 and FLAT = 2 builds an 8-tap variant. It follows R2 to R5 with that response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NCH | One sample-valid flag per lane |
| in_sample | input | NCH*IN_W | Lane samples, lane c in bits [c*IN_W +: IN_W] |
| out_valid | output | NCH | One result-valid flag per lane |
| out_sample | output | NCH*OUT_W | Shaped results, lane c in bits [c*OUT_W +: OUT_W] |

## Verification
The bench aims at the sign bit plane. It holds full-scale positive and negative runs, and a design that added the top plane instead of subtracting it would return large wrong magnitudes there. It streams ±1 to ±4 so that sums land on exact halves. A design that truncated, or rounded ties away from zero, would be off by one on the negative results. It drops valid flags on random cycles, and a design that shifted on every clock would smear results across gaps and emit extra outputs. Ramped steps of several rise times must all give the same plateau. A mid-stream reset must start from clean history, otherwise stale taps would leak into the first 16 results.

// File: rtl/shaper_pkg.sv
`timescale 1ns/1ps
package shaper_pkg;

    // Tap weight at position idx of the trapezoid response.
    function automatic int tap_coef(input int idx, input int rise, input int flat, input int gain);
        if (idx < rise)
            return gain;
        else if (idx < rise + flat)
            return 0;
        return -gain;
    endfunction

    // Sum of the coefficients of one tap group selected by the bits of sel.
    function automatic int rom_word(input int grp, input int sel, input int grp_taps,
                                    input int rise, input int flat, input int gain);
        int s;
        int t;
        s = 0;
        for (int j = 0; j < grp_taps; j++) begin
            t = grp * grp_taps + j;
            if (t < 2 * rise + flat && sel[j])
                s += tap_coef(t, rise, flat, gain);
        end
        return s;
    endfunction

endpackage

// File: rtl/shaper_rom.sv
`timescale 1ns/1ps
module shaper_rom
    import shaper_pkg::*;
#(
    parameter int GRP      = 0,
    parameter int GRP_TAPS = 4,
    parameter int RISE     = 6,
    parameter int FLAT     = 4,
    parameter int GAIN     = 3,
    parameter int W        = 7
) (
    input  logic [GRP_TAPS-1:0] addr,
    output logic signed [W-1:0] word
);
    localparam int DEPTH = 2 ** GRP_TAPS;

    logic signed [W-1:0] rom_tbl [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        assign rom_tbl[e] = W'(rom_word(GRP, e, GRP_TAPS, RISE, FLAT, GAIN));
    end

    assign word = rom_tbl[addr];
endmodule

// File: rtl/shaper_channel.sv
`timescale 1ns/1ps
module shaper_channel #(
    parameter int IN_W     = 14,
    parameter int RISE     = 6,
    parameter int FLAT     = 4,
    parameter int GAIN     = 3,
    parameter int SHIFT    = 1,
    parameter int OUT_W    = 19,
    parameter int GRP_TAPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);
    localparam int NTAPS   = 2 * RISE + FLAT;
    localparam int NGRP    = (NTAPS + GRP_TAPS - 1) / GRP_TAPS;
    localparam int ABS_SUM = 2 * RISE * GAIN;
    localparam int PS_W    = $clog2(ABS_SUM + 1) + 1;
    localparam int ACC_W   = IN_W + PS_W;
    localparam int HALF    = (SHIFT > 0) ? (1 << (SHIFT - 1)) : 0;

    typedef struct packed {
        logic [NTAPS-1:0][IN_W-1:0] taps;
        logic                       v1;
        logic [IN_W-1:0][PS_W-1:0]  psum;
        logic                       v2;
        logic                       v3;
        logic [OUT_W-1:0]           res;
    } state_t;

    state_t st_d, st_q;

    logic [IN_W-1:0][NGRP-1:0][GRP_TAPS-1:0] addr;
    logic signed [PS_W-1:0]  word    [IN_W][NGRP];
    logic signed [PS_W-1:0]  bit_sum [IN_W];
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;

    // One table lookup per bit plane and tap group.
    for (genvar b = 0; b < IN_W; b++) begin : g_bit
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            for (genvar j = 0; j < GRP_TAPS; j++) begin : g_sel
                if (g * GRP_TAPS + j < NTAPS) begin : g_tap
                    assign addr[b][g][j] = st_q.taps[g*GRP_TAPS+j][b];
                end else begin : g_pad
                    assign addr[b][g][j] = 1'b0;
                end
            end
            shaper_rom #(
                .GRP(g), .GRP_TAPS(GRP_TAPS), .RISE(RISE),
                .FLAT(FLAT), .GAIN(GAIN), .W(PS_W)
            ) u_rom (
                .addr(addr[b][g]),
                .word(word[b][g])
            );
        end
    end

    always_comb begin
        for (int b = 0; b < IN_W; b++) begin
            bit_sum[b] = '0;
            for (int g = 0; g < NGRP; g++)
                bit_sum[b] = bit_sum[b] + word[b][g];
        end
    end

    // Weighted plane combination; the sign plane counts negative.
    always_comb begin
        acc = '0;
        for (int b = 0; b < IN_W; b++) begin
            if (b == IN_W - 1)
                acc = acc - (ACC_W'($signed(st_q.psum[b])) <<< b);
            else
                acc = acc + (ACC_W'($signed(st_q.psum[b])) <<< b);
        end
        rnd = (acc + ACC_W'(HALF)) >>> SHIFT;
    end

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        st_d.v2 = st_q.v1;
        st_d.v3 = st_q.v2;
        if (in_valid) begin
            st_d.taps[0] = in_sample;
            for (int i = 1; i < NTAPS; i++)
                st_d.taps[i] = st_q.taps[i-1];
        end
        if (st_q.v1) begin
            for (int b = 0; b < IN_W; b++)
                st_d.psum[b] = bit_sum[b];
        end
        if (st_q.v2)
            st_d.res = OUT_W'(rnd);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.v3;
    assign out_sample = st_q.res;
endmodule

// File: rtl/trapezoid_shaper.sv
`timescale 1ns/1ps
module trapezoid_shaper #(
    parameter int NCH      = 4,
    parameter int IN_W     = 14,
    parameter int RISE     = 6,
    parameter int FLAT     = 4,
    parameter int GAIN     = 3,
    parameter int SHIFT    = 1,
    parameter int OUT_W    = 19,
    parameter int GRP_TAPS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       in_valid,
    input  logic [NCH*IN_W-1:0]  in_sample,
    output logic [NCH-1:0]       out_valid,
    output logic [NCH*OUT_W-1:0] out_sample
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        shaper_channel #(
            .IN_W(IN_W), .RISE(RISE), .FLAT(FLAT), .GAIN(GAIN),
            .SHIFT(SHIFT), .OUT_W(OUT_W), .GRP_TAPS(GRP_TAPS)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid[c]),
            .in_sample (in_sample[c*IN_W +: IN_W]),
            .out_valid (out_valid[c]),
            .out_sample(out_sample[c*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/shaper_checker.sv
`timescale 1ns/1ps
module shaper_checker #(
    parameter int NCH   = 4,
    parameter int IN_W  = 14,
    parameter int RISE  = 6,
    parameter int GAIN  = 3,
    parameter int SHIFT = 1,
    parameter int OUT_W = 19
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NCH-1:0]       in_valid,
    input logic [NCH-1:0]       out_valid,
    input logic [NCH*OUT_W-1:0] out_sample
);
    localparam int HALF  = (SHIFT > 0) ? (1 << (SHIFT - 1)) : 0;
    localparam int BOUND = (2 * RISE * GAIN * (2 ** (IN_W - 1)) + HALF) >>> SHIFT;

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R1: reset empties the outputs
    p_out_idle_r1: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_sample == '0));

    // R4: each valid sample returns three edges later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        // R5: result holds between valid outputs
        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (age != 2'd0 && !out_valid[c]) |-> $stable(out_sample[c*OUT_W +: OUT_W]));

        // R7: result magnitude within full-scale bound
        p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
            out_valid[c] |-> ($signed(out_sample[c*OUT_W +: OUT_W]) <= BOUND &&
                              $signed(out_sample[c*OUT_W +: OUT_W]) >= -BOUND));
    end
endmodule

bind trapezoid_shaper shaper_checker #(
    .NCH(NCH), .IN_W(IN_W), .RISE(RISE), .GAIN(GAIN), .SHIFT(SHIFT), .OUT_W(OUT_W)
) u_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sample(out_sample)
);

// File: tb/tb_trapezoid_shaper.sv
`timescale 1ns/1ps
module tb_trapezoid_shaper;
    localparam int NCH   = 4;
    localparam int IN_W  = 14;
    localparam int OUT_W = 19;
    localparam int GAIN  = 3;
    localparam int SHIFT = 1;
    localparam int HALF  = 1;
    localparam int R16 = 6, F16 = 4, N16 = 16;
    localparam int R8  = 3, F8  = 2, N8  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]       vin = '0;
    int                   dval [NCH];
    logic [NCH*IN_W-1:0]  flat_in;
    logic [NCH-1:0]       vout;
    logic [NCH*OUT_W-1:0] flat_out;
    logic                 v8;
    logic [OUT_W-1:0]     out8;

    int hist  [NCH][N16];
    int hist8 [N8];
    int expq  [NCH][$];
    int stq   [NCH][$];
    int exp8q [$];
    int st8q  [$];
    int last  [NCH];
    int peak  [NCH];
    int last8;
    int cyc = 0, n_run = 0, n_fail = 0, seed = 7;
    string tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb
        for (int c = 0; c < NCH; c++)
            flat_in[c*IN_W +: IN_W] = IN_W'(dval[c]);

    trapezoid_shaper dut (
        .clk(clk), .rst(rst), .in_valid(vin), .in_sample(flat_in),
        .out_valid(vout), .out_sample(flat_out)
    );

    trapezoid_shaper #(.NCH(1), .RISE(R8), .FLAT(F8)) dut8 (
        .clk(clk), .rst(rst), .in_valid(vin[0:0]), .in_sample(flat_in[IN_W-1:0]),
        .out_valid(v8), .out_sample(out8)
    );

    function automatic int coef(input int i, input int rise, input int flat);
        if (i < rise) return GAIN;
        if (i < rise + flat) return 0;
        return -GAIN;
    endfunction

    function automatic int ref_round(input int a);
        return (a + HALF) >>> SHIFT;
    endfunction

    function automatic int rnd14();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 16'h3FFF) - 8192;
    endfunction

    task automatic check(input bit ok, input string t, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic step(input logic [NCH-1:0] v, input int d0, input int d1, input int d2, input int d3);
        int d [NCH];
        int acc;
        d = '{d0, d1, d2, d3};
        @(negedge clk);
        vin = v;
        for (int c = 0; c < NCH; c++) begin
            dval[c] = d[c];
            if (v[c]) begin
                for (int i = N16 - 1; i > 0; i--) hist[c][i] = hist[c][i-1];
                hist[c][0] = d[c];
                acc = 0;
                for (int i = 0; i < N16; i++) acc += coef(i, R16, F16) * hist[c][i];
                expq[c].push_back(ref_round(acc));
                stq[c].push_back(cyc + 3);
            end
        end
        if (v[0]) begin
            for (int i = N8 - 1; i > 0; i--) hist8[i] = hist8[i-1];
            hist8[0] = d[0];
            acc = 0;
            for (int i = 0; i < N8; i++) acc += coef(i, R8, F8) * hist8[i];
            exp8q.push_back(ref_round(acc));
            st8q.push_back(cyc + 3);
        end
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < N16; i++) hist[c][i] = 0;
            expq[c].delete();
            stq[c].delete();
            last[c] = 0;
            peak[c] = 0;
        end
        for (int i = 0; i < N8; i++) hist8[i] = 0;
        exp8q.delete();
        st8q.delete();
        last8 = 0;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        vin = '0;
        clear_model();
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                int got, e, s;
                got = $signed(flat_out[c*OUT_W +: OUT_W]);
                if (vout[c]) begin
                    if (expq[c].size() == 0) begin
                        check(1'b0, "R4", "unexpected result", got, 0);
                    end else begin
                        e = expq[c].pop_front();
                        s = stq[c].pop_front();
                        check(got == e, tag, "lane result", got, e);
                        check(s == cyc, "R4", "result cycle", cyc, s);
                        last[c] = got;
                        if (got > peak[c]) peak[c] = got;
                    end
                end else begin
                    check(got == last[c], "R5", "held result", got, last[c]);
                    if (stq[c].size() != 0 && stq[c][0] <= cyc) begin
                        check(1'b0, "R4", "missing result", cyc, stq[c][0]);
                        e = expq[c].pop_front();
                        s = stq[c].pop_front();
                    end
                end
            end
            begin
                int got8, e8, s8;
                got8 = $signed(out8);
                if (v8) begin
                    if (exp8q.size() == 0) begin
                        check(1'b0, "R9", "unexpected result", got8, 0);
                    end else begin
                        e8 = exp8q.pop_front();
                        s8 = st8q.pop_front();
                        check(got8 == e8 && s8 == cyc, "R9", "8-tap result", got8, e8);
                        last8 = got8;
                    end
                end else begin
                    check(got8 == last8, "R9", "8-tap hold", got8, last8);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            check(1'b0, "WD", "watchdog expired", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) dval[c] = 0;
        clear_model();
        repeat (3) @(negedge clk);
        check(vout == '0 && v8 == 1'b0, "R1", "valid in reset", int'(vout), 0);
        check(flat_out == '0 && out8 == '0, "R1", "result in reset", 1, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 impulses, including +-1 for rounding
        tag = "R2";
        step(4'hF, 100, -57, 1, -1);
        repeat (20) step(4'hF, 0, 0, 0, 0);

        // R3 small values landing on halves
        tag = "R3";
        repeat (30) step(4'hF, (rnd14() & 7) - 3, (rnd14() & 7) - 3, (rnd14() & 7) - 3, (rnd14() & 7) - 3);
        repeat (20) step(4'hF, 0, 0, 0, 0);

        // R6 ramped steps of rise 1, 2, 4, 5
        tag = "R6";
        for (int c = 0; c < NCH; c++) peak[c] = 0;
        for (int k = 0; k < 30; k++) begin
            int r [NCH];
            int x [NCH];
            r = '{1, 2, 4, 5};
            for (int c = 0; c < NCH; c++)
                x[c] = (k <= 0) ? 0 : ((k >= r[c]) ? 1000 : (1000 * k) / r[c]);
            step(4'hF, x[0], x[1], x[2], x[3]);
        end
        repeat (6) step(4'h0, 0, 0, 0, 0);
        for (int c = 0; c < NCH; c++)
            check(peak[c] == 9000, "R6", "plateau height", peak[c], 9000);
        repeat (20) step(4'hF, 0, 0, 0, 0);

        // R5 gaps in valid
        tag = "R5";
        repeat (60) begin
            int msk;
            msk = rnd14();
            step(4'(msk), rnd14(), rnd14(), rnd14(), rnd14());
        end

        // R7 full-scale runs
        tag = "R7";
        repeat (2) begin
            repeat (12) step(4'hF, 8191, -8192, 8191, -8192);
            repeat (12) step(4'hF, -8192, 8191, -8192, 8191);
        end

        // R8 independent lanes, lane 2 idle
        tag = "R8";
        repeat (40) step(4'hB, rnd14(), rnd14(), 777, rnd14());
        repeat (5) step(4'h0, 0, 0, 0, 0);

        // R1 mid-stream reset clears history
        repeat (10) step(4'hF, 5000, -4000, 3000, -2000);
        do_reset(3);
        tag = "R1";
        step(4'hF, 50, 50, 50, 50);
        repeat (18) step(4'hF, 0, 0, 0, 0);

        repeat (10) step(4'h0, 0, 0, 0, 0);
        for (int c = 0; c < NCH; c++)
            check(expq[c].size() == 0, "R4", "results outstanding", expq[c].size(), 0);
        check(exp8q.size() == 0, "R9", "8-tap results outstanding", exp8q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule